// File: doc/BRIEF.md
# Double-Bank Transmit Buffer with Short-Bank Seal

This block sits between a DMA engine that pushes bytes and a serial transmitter that pulls them. It holds two banks of 32 bytes. One bank is being filled through the byte write port while the other is being drained through the byte read port. When the filling bank is full and the draining bank has been emptied, the banks trade roles. Each such trade of a full bank asks the DMA engine for another 32-byte burst.

A transfer whose length is not a multiple of 32 leaves the last bank only partly filled, and that bank never trades roles on its own. Software pulses a seal strobe, which marks the partly filled bank as complete. The bank then trades roles as soon as the drain side is free, and the transmitter sends exactly the bytes that were written into it. If the drain side is still busy, the seal is remembered until that bank empties.

Top module: `pingpong_tx_buffer`

## Requirements
- R1: After reset both banks are empty: `wr_ready` is 1, `rd_valid` is 0 and `dma_req` is 1.
- R2: Each bank holds 32 bytes. A full fill bank drops `wr_ready` to 0, and a write offered while `wr_ready` is 0 is not taken. With the read side stalled, exactly 64 bytes are accepted from a continuous write stream and none is lost.
- R3: When the fill bank holds 32 bytes and the drain bank is empty, the banks trade roles on the next clock edge: `rd_valid` rises and `wr_ready` returns to 1.
- R4: A role trade of a bank holding 32 bytes sets `dma_req` to 1. `dma_req` then stays at 1 until a byte is accepted (`wr_valid` and `wr_ready` both 1 at an edge), and it is 0 from that edge on.
- R5: Bytes leave on `rd_data` in the order they were written, one per edge on which `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold.
- R6: A seal strobe on a fill bank holding 1 to 31 bytes makes that bank trade roles once the drain bank is empty. Only the bytes written into it are sent, and the trade of a short bank does not set `dma_req`.
- R7: A seal strobe given while the drain bank is still sending is held pending. Until the trade, `wr_ready` stays 0, and the trade happens once the drain bank empties.
- R8: A seal strobe on an empty fill bank, with no write on the same edge, is ignored: no trade happens, `rd_valid` stays 0 and `wr_ready` stays 1.
- R9: A byte accepted on the same edge as a seal strobe belongs to the sealed bank and is sent with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | DMA side offers a byte |
| wr_data | input | DATA_W | Byte offered by the DMA side |
| wr_ready | output | 1 | Fill bank can take a byte |
| seal_strobe | input | 1 | One-cycle command that marks the fill bank complete |
| rd_valid | output | 1 | Drain bank has a byte for the transmitter |
| rd_data | output | DATA_W | Next byte of the drain bank |
| rd_ready | input | 1 | Transmitter takes the byte |
| dma_req | output | 1 | Request for another 32-byte burst |

## Verification
A wrong fill count shows at the ports within one write as a `wr_ready` edge in the wrong cycle, or as a byte count out of step with the reads. A wrong drain pointer or bank select shows on the first read as a byte out of order, or as `rd_valid` lasting too long or too short. The reference model therefore compares all four outputs on every clock. Any error in the select, count or pending state shows up at most one bank (32 transfers) later. A lost seal shows as a stream that never finishes draining. A seal that fires wrongly shows as an early `rd_valid` or as a `dma_req` pulse in the wrong cycle.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic { BANK_A = 1'b0, BANK_B = 1'b1 } bank_sel_e;
endpackage

// File: rtl/ptb_bank_mem.sv
module ptb_bank_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // storage needs no reset: the counts gate every read
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ptb_fill_ctrl.sv
module ptb_fill_ctrl
  import ptb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             seal_strobe,
  input  logic             drain_empty,
  output logic             wr_ready,
  output logic             wr_fire,
  output logic [PTR_W-1:0] waddr,
  output logic             fill_bank,
  output logic             swap,
  output logic [CNT_W-1:0] swap_cnt,
  output logic             dma_req
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  bank_sel_e        sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             dma_q, dma_d;
  logic             full;
  logic             state_en;

  assign full     = (cnt_q == FULL_CNT);
  assign wr_ready = !full && !pend_q;
  assign wr_fire  = wr_valid && wr_ready;
  assign swap     = drain_empty && (full || pend_q);
  assign swap_cnt = cnt_q;
  assign waddr    = cnt_q[PTR_W-1:0];
  assign fill_bank = (sel_q == BANK_B);
  assign dma_req  = dma_q;
  assign state_en = swap || wr_fire || seal_strobe;

  always_comb begin
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    dma_d  = dma_q;
    if (swap) begin
      sel_d  = (sel_q == BANK_A) ? BANK_B : BANK_A;
      cnt_d  = '0;
      pend_d = 1'b0;
      if (full) begin
        dma_d = 1'b1;
      end
    end else begin
      if (wr_fire) begin
        cnt_d = cnt_q + CNT_W'(1);
        dma_d = 1'b0;
      end
      if (seal_strobe && ((cnt_q != '0) || wr_fire)) begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= BANK_A;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      dma_q  <= 1'b1;
    end else if (state_en) begin
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      dma_q  <= dma_d;
    end
  end
endmodule

// File: rtl/ptb_drain_ctrl.sv
module ptb_drain_ctrl #(
  parameter int CNT_W = 6,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [PTR_W-1:0] raddr,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] ptr_ext;
  logic             rd_fire;
  logic             last;
  logic             state_en;

  assign empty    = (cnt_q == '0);
  assign rd_valid = !empty;
  assign raddr    = ptr_q;
  assign rd_fire  = rd_valid && rd_ready;
  assign ptr_ext  = CNT_W'(ptr_q);
  assign last     = ((ptr_ext + CNT_W'(1)) == cnt_q);
  assign state_en = load || rd_fire;

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    if (load) begin
      cnt_d = load_cnt;
      ptr_d = '0;
    end else if (rd_fire) begin
      if (last) begin
        cnt_d = '0;
        ptr_d = '0;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (state_en) begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/pingpong_tx_buffer.sv
module pingpong_tx_buffer #(
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              seal_strobe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              dma_req
);
  localparam int CNT_W   = $clog2(BANK_DEPTH + 1);
  localparam int PTR_W   = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int N_BANKS = 2;

  logic              wr_fire;
  logic [PTR_W-1:0]  waddr;
  logic [PTR_W-1:0]  raddr;
  logic              fill_bank;
  logic              swap;
  logic [CNT_W-1:0]  swap_cnt;
  logic              drain_empty;
  logic [DATA_W-1:0] bank_rdata [N_BANKS];

  ptb_fill_ctrl #(
    .DEPTH (BANK_DEPTH),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .seal_strobe (seal_strobe),
    .drain_empty (drain_empty),
    .wr_ready    (wr_ready),
    .wr_fire     (wr_fire),
    .waddr       (waddr),
    .fill_bank   (fill_bank),
    .swap        (swap),
    .swap_cnt    (swap_cnt),
    .dma_req     (dma_req)
  );

  ptb_drain_ctrl #(
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (swap),
    .load_cnt (swap_cnt),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .raddr    (raddr),
    .empty    (drain_empty)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_fire && (fill_bank == b[0]);

    ptb_bank_mem #(
      .DATA_W (DATA_W),
      .DEPTH  (BANK_DEPTH),
      .PTR_W  (PTR_W)
    ) u_mem (
      .clk   (clk),
      .we    (bank_we),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (bank_rdata[b])
    );
  end

  assign rd_data = bank_rdata[!fill_bank];
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              dma_req
);
  // R4: request held until a byte is taken
  a_r4_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !(wr_valid && wr_ready) |=> dma_req);

  // R4: first accepted byte clears the request
  a_r4_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && wr_valid && wr_ready |=> !dma_req);

  // R5: stalled output holds
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R3: sealed fill bank with idle drain side trades on the next edge
  a_r3_swap_next: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !wr_ready |=> rd_valid && wr_ready);

  // R2: refusal persists while the drain side is stalled
  a_r2_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready && rd_valid && !rd_ready |=> !wr_ready);
endmodule

bind pingpong_tx_buffer ptb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .dma_req  (dma_req)
);

// File: tb/pingpong_tx_buffer_tb.sv
module pingpong_tx_buffer_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          seal = 1'b0;
  logic          rd_ready = 1'b0;
  logic          wr_ready, rd_valid, dma_req;
  logic [DW-1:0] rd_data;

  always #10 clk = ~clk;

  pingpong_tx_buffer #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .seal_strobe(seal), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready), .dma_req(dma_req)
  );

  int checks = 0;
  int errors = 0;
  int n_wr = 0;
  int n_rd = 0;
  int cycles = 0;
  bit done = 0;

  logic [DW-1:0] fq[$];
  logic [DW-1:0] dq[$];
  bit pend = 0;
  bit mdma = 1;

  function automatic bit m_wr_ready();
    return (fq.size() < DEPTH) && !pend;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  // behavioural reference: two byte queues and a pending flag
  always @(posedge clk) begin
    bit wf, rf, sw;
    if (!rst_n) begin
      fq.delete(); dq.delete(); pend = 0; mdma = 1;
    end else begin
      wf = wr_valid && m_wr_ready();
      rf = rd_ready && (dq.size() != 0);
      sw = (dq.size() == 0) && ((fq.size() == DEPTH) || pend);
      if (sw) begin
        if (fq.size() == DEPTH) mdma = 1;
        dq = fq;
        fq.delete();
        pend = 0;
      end else begin
        if (wf) begin
          fq.push_back(wr_data);
          mdma = 0;
          n_wr++;
        end
        if (seal && (fq.size() != 0)) pend = 1;
        if (rf) begin
          void'(dq.pop_front());
          n_rd++;
        end
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", 32'(wr_ready), 32'(m_wr_ready()), "wr_ready");
      chk("R3", 32'(rd_valid), 32'(dq.size() != 0), "rd_valid");
      chk("R4", 32'(dma_req), 32'(mdma), "dma_req");
      if (dq.size() != 0) chk("R5", 32'(rd_data), 32'(dq[0]), "rd_data");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected<=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base_w, base_r, guard;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1", 32'(wr_ready), 1, "wr_ready after reset");
    chk("R1", 32'(rd_valid), 0, "rd_valid after reset");
    chk("R1", 32'(dma_req), 1, "dma_req after reset");

    // R8 seal on empty fill bank
    seal = 1'b1; step(); seal = 1'b0;
    repeat (3) step();
    chk("R8", 32'(rd_valid), 0, "rd_valid after empty seal");
    chk("R8", 32'(wr_ready), 1, "wr_ready after empty seal");
    chk("R8", 32'(dma_req), 1, "dma_req after empty seal");

    // R9 / R6 short bank: seal together with the third byte
    rd_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1; wr_data = DW'(8'hA0 + i); seal = (i == 2);
      step();
    end
    wr_valid = 1'b0; seal = 1'b0;
    repeat (3) step();
    chk("R9", 32'(rd_valid), 1, "rd_valid after seal with write");
    chk("R6", 32'(dma_req), 0, "dma_req after short trade");
    chk("R6", 32'(wr_ready), 1, "wr_ready after short trade");
    base_r = n_rd;
    rd_ready = 1'b1;
    repeat (8) step();
    rd_ready = 1'b0;
    chk("R9", 32'(n_rd - base_r), 3, "bytes sent from short bank");

    // R2 stalled reader, continuous writes
    base_w = n_wr;
    wr_valid = 1'b1;
    for (int i = 0; i < 80; i++) begin
      wr_data = DW'(i);
      step();
    end
    wr_valid = 1'b0;
    chk("R2", 32'(n_wr - base_w), 64, "bytes accepted while stalled");
    chk("R2", 32'(wr_ready), 0, "wr_ready with both banks full");
    chk("R4", 32'(dma_req), 0, "dma_req after burst taken");
    base_r = n_rd;
    rd_ready = 1'b1;
    repeat (80) step();
    rd_ready = 1'b0;
    chk("R3", 32'(n_rd - base_r), 64, "bytes sent after two trades");
    chk("R4", 32'(dma_req), 1, "dma_req after full trade");

    // R7 seal pending while drain bank busy
    base_w = n_wr;
    guard = 0;
    wr_valid = 1'b1;
    while ((n_wr - base_w) < 42 && guard < 200) begin
      wr_data = DW'(8'h40 + (n_wr - base_w));
      step();
      guard++;
    end
    wr_valid = 1'b0;
    seal = 1'b1; step(); seal = 1'b0;
    repeat (4) step();
    chk("R7", 32'(wr_ready), 0, "wr_ready with seal pending");
    chk("R7", 32'(rd_valid), 1, "rd_valid with seal pending");
    base_r = n_rd;
    rd_ready = 1'b1;
    repeat (60) step();
    rd_ready = 1'b0;
    chk("R7", 32'(n_rd - base_r), 42, "bytes sent after pending seal");
    chk("R6", 32'(wr_ready), 1, "wr_ready after pending trade");

    // random traffic with occasional seals
    for (int i = 0; i < 4000; i++) begin
      wr_valid = 1'($urandom % 2);
      wr_data  = DW'($urandom);
      rd_ready = (($urandom % 4) != 0);
      seal     = (($urandom % 50) == 0);
      step();
    end
    wr_valid = 1'b0;
    seal = 1'b1; step(); seal = 1'b0;
    rd_ready = 1'b1;
    repeat (120) step();
    chk("R6", 32'(rd_valid), 0, "rd_valid after final seal");
    chk("R5", 32'(n_rd), 32'(n_wr), "total bytes read vs written");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule